// File: doc/BRIEF.md
# Thermostat Alert Generator with Fault Queue

This block watches a stream of finished temperature samples and decides when a thermostat alert should be raised. Each sample is a 13-bit two's-complement value. It is compared with an upper limit and a lower limit that are held elsewhere. A programmable fault queue requires a run of consecutive out-of-range samples before the alert state can change, so a single noisy reading cannot trigger it.

Three thermostat behaviours are available.

- **Comparator:** this is the reset behaviour. The alert is raised after a run of hot samples and dropped after a run of cold samples.
- **Interrupt:** the alert is raised on a hot run and held until a register read or entry into shutdown. The block then watches for a cold run, which raises the alert again until the next read. After that it watches for a hot run, and the cycle repeats.
- **Mixed:** the alert is raised like comparator mode. It is dropped only when a cold run has completed and a later register access has taken place.

A polarity bit selects whether the output is active low (the default) or active high. The output is meant to drive an open-drain pad.

A sample is delivered with a one-cycle strobe. The block accepts a sample on every cycle and exerts no back-pressure. The upstream converter may present a sample at any time, and a sample that arrives without its strobe is never seen.

Top module: `tstat_alert`

## Requirements
- R1: After reset the alert is inactive, so `alert_o` is 1 with `alert_pol`=0. Both fault runs start from zero.
- R2: A sample is hot when it is greater than or equal to `lim_hi`. A sample is cold when it is strictly below `lim_lo`. Both comparisons are signed and use all 13 bits.
- R3: `fq_sel` values 0, 1, 2 and 3 require 1, 2, 4 and 6 consecutive hot (or cold) samples respectively. Any sample that is not hot resets the hot run, and any sample that is not cold resets the cold run.
- R4: With `tmode`=0 (comparator), the alert asserts once a hot run reaches the queue length and deasserts once a cold run does. `tmode`=3 behaves identically.
- R5: With `tmode`=1 (interrupt), an asserted alert stays asserted through any samples until `rd_stb` is seen or `shutdown` rises.
- R6: In interrupt mode, each clear flips the watched direction. After a clear following a hot alert, only a qualifying cold run reasserts the alert. After the next clear, only a qualifying hot run does.
- R7: With `tmode`=2 (mixed), the alert asserts on a qualifying hot run. It deasserts only on an `rd_stb` that occurs in a cycle after a qualifying cold run has completed. A read before that has no effect.
- R8: `alert_pol`=0 drives the alert active low and `alert_pol`=1 drives it active high. The pin follows a polarity change without waiting for a clock.
- R9: When `rd_stb` coincides with a qualifying sample, the clear is applied first and the new sample is evaluated afterwards.
- R10: Fault runs and the alert state change only on cycles with `smp_vld` high. In comparator mode, `rd_stb` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe marking a finished conversion |
| smp_temp | input | 13 | Signed sample, 1/16 degree per LSB |
| lim_hi | input | 13 | Signed upper limit |
| lim_lo | input | 13 | Signed lower limit |
| tmode | input | 2 | Thermostat behaviour: 0 comparator, 1 interrupt, 2 mixed, 3 comparator |
| fq_sel | input | 2 | Fault queue length select |
| alert_pol | input | 1 | 0 active low, 1 active high |
| rd_stb | input | 1 | One-cycle pulse for any register read or bus access |
| shutdown | input | 1 | Shutdown level; a rising edge clears an interrupt alert |
| alert_o | output | 1 | Alert level toward the open-drain pad |

## Verification
A register read and a newly qualifying sample can land in the same cycle. The read tries to clear the alert, while the sample tries to set it or arm it.

The bench provokes this in two modes by pulsing `rd_stb` together with `smp_vld`:

- **Mixed mode:** the read arrives while a cold run is pending and carries a hot sample. Applying the clear and then the hot sample must leave the alert asserted.
- **Interrupt mode:** a read arrives with a hot sample and must leave the alert deasserted, because the watched direction has just flipped to cold. A read then arrives with a cold sample while the alert is idle, and the alert must assert.

// File: rtl/tstat_pkg.sv
package tstat_pkg;
  localparam int TEMP_W = 13;
  localparam int CNT_W  = 3;

  typedef enum logic [1:0] {
    TM_CMP = 2'b00,
    TM_INT = 2'b01,
    TM_MIX = 2'b10,
    TM_RSV = 2'b11
  } tmode_e;

  // queue select -> run length needed
  function automatic logic [CNT_W-1:0] run_need(input logic [1:0] sel);
    case (sel)
      2'd0:    run_need = CNT_W'(1);
      2'd1:    run_need = CNT_W'(2);
      2'd2:    run_need = CNT_W'(4);
      default: run_need = CNT_W'(6);
    endcase
  endfunction
endpackage

// File: rtl/tstat_cmp.sv
module tstat_cmp #(
  parameter int TW = 13
) (
  input  logic signed [TW-1:0] temp,
  input  logic signed [TW-1:0] hi_lim,
  input  logic signed [TW-1:0] lo_lim,
  output logic [1:0]           hit     // [0] hot, [1] cold
);
  always_comb begin
    hit[0] = (temp >= hi_lim);
    hit[1] = (temp <  lo_lim);
  end
endmodule

// File: rtl/tstat_fault_q.sv
module tstat_fault_q #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic          is_hit,
  input  logic [CW-1:0] need,
  output logic          qual
);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  logic [CW-1:0] run;
  logic [CW:0]   run_inc;

  assign run_inc = {1'b0, run} + (CW+1)'(1);
  assign qual    = smp_vld && is_hit && (run_inc >= {1'b0, need});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
    end else if (smp_vld) begin
      if (!is_hit)         run <= '0;
      else if (run != SAT) run <= run_inc[CW-1:0];
    end
  end
endmodule

// File: rtl/tstat_alert_fsm.sv
module tstat_alert_fsm
  import tstat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       hi_qual,
  input  logic       lo_qual,
  input  logic       rd_stb,
  input  logic       sd_rise,
  output logic       act
);
  logic act_n;
  logic watch_lo, watch_lo_n;   // interrupt: armed for cold run
  logic pend, pend_n;           // mixed: cold run done, waiting access

  always_comb begin
    act_n      = act;
    watch_lo_n = watch_lo;
    pend_n     = pend;
    case (tmode_e'(mode))
      TM_INT: begin
        pend_n = 1'b0;
        if ((rd_stb || sd_rise) && act) begin
          act_n      = 1'b0;
          watch_lo_n = !watch_lo;
        end
        if (!act_n && (watch_lo_n ? lo_qual : hi_qual)) act_n = 1'b1;
      end
      TM_MIX: begin
        watch_lo_n = 1'b0;
        if (act && pend && rd_stb) begin
          act_n  = 1'b0;
          pend_n = 1'b0;
        end
        if (hi_qual) begin
          act_n  = 1'b1;
          pend_n = 1'b0;
        end else if (lo_qual && act_n) begin
          pend_n = 1'b1;
        end
      end
      default: begin
        watch_lo_n = 1'b0;
        pend_n     = 1'b0;
        if (hi_qual)      act_n = 1'b1;
        else if (lo_qual) act_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      watch_lo <= 1'b0;
      pend     <= 1'b0;
    end else begin
      act      <= act_n;
      watch_lo <= watch_lo_n;
      pend     <= pend_n;
    end
  end
endmodule

// File: rtl/tstat_alert.sv
module tstat_alert
  import tstat_pkg::*;
#(
  parameter int TW = TEMP_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [TW-1:0] smp_temp,
  input  logic [TW-1:0] lim_hi,
  input  logic [TW-1:0] lim_lo,
  input  logic [1:0]    tmode,
  input  logic [1:0]    fq_sel,
  input  logic          alert_pol,
  input  logic          rd_stb,
  input  logic          shutdown,
  output logic          alert_o
);
  localparam int NDIR = 2;

  logic [NDIR-1:0] hit;
  logic [NDIR-1:0] qual;
  logic [CW-1:0]   need;
  logic            sd_q;
  logic            act;

  assign need = CW'(run_need(fq_sel));

  tstat_cmp #(.TW(TW)) u_cmp (
    .temp   (signed'(smp_temp)),
    .hi_lim (signed'(lim_hi)),
    .lo_lim (signed'(lim_lo)),
    .hit    (hit)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_run
    tstat_fault_q #(.CW(CW)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_vld (smp_vld),
      .is_hit  (hit[d]),
      .need    (need),
      .qual    (qual[d])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_q <= 1'b0;
    else        sd_q <= shutdown;
  end

  tstat_alert_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (tmode),
    .hi_qual (qual[0]),
    .lo_qual (qual[1]),
    .rd_stb  (rd_stb),
    .sd_rise (shutdown && !sd_q),
    .act     (act)
  );

  assign alert_o = alert_pol ? act : !act;
endmodule

// File: rtl/tstat_alert_chk.sv
module tstat_alert_chk #(
  parameter int TW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic [TW-1:0] smp_temp,
  input logic [TW-1:0] lim_hi,
  input logic [TW-1:0] lim_lo,
  input logic [1:0]    tmode,
  input logic [1:0]    fq_sel,
  input logic          rd_stb,
  input logic          shutdown,
  input logic          act
);
  logic hot, cold;
  assign hot  = $signed(smp_temp) >= $signed(lim_hi);
  assign cold = $signed(smp_temp) <  $signed(lim_lo);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !rd_stb && !shutdown) |=> $stable(act));

  // R4
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode == 2'd0 && fq_sel == 2'd0 && smp_vld && hot) |=> act);

  // R2
  cmp_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode == 2'd0 && fq_sel == 2'd0 && smp_vld && cold && !hot) |=> !act);

  // R5
  int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode == 2'd1 && act && !rd_stb && !shutdown) |=> act);

  // R7
  mix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode == 2'd2 && act && !rd_stb) |=> act);
endmodule

bind tstat_alert tstat_alert_chk #(.TW(TW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_vld  (smp_vld),
  .smp_temp (smp_temp),
  .lim_hi   (lim_hi),
  .lim_lo   (lim_lo),
  .tmode    (tmode),
  .fq_sel   (fq_sel),
  .rd_stb   (rd_stb),
  .shutdown (shutdown),
  .act      (act)
);

// File: tb/test_tstat_alert.sv
module test_tstat_alert;
  localparam int TW = 13;
  localparam logic [TW-1:0] HI   = 13'd1280;  // 80 C
  localparam logic [TW-1:0] LO   = 13'd1200;  // 75 C
  localparam logic [TW-1:0] MID  = 13'd1240;
  localparam logic [TW-1:0] HOT  = 13'd1400;
  localparam logic [TW-1:0] COLD = 13'd1100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_vld = 1'b0;
  logic [TW-1:0] smp_temp = '0;
  logic [TW-1:0] lim_hi = HI;
  logic [TW-1:0] lim_lo = LO;
  logic [1:0]    tmode = 2'd0;
  logic [1:0]    fq_sel = 2'd0;
  logic          alert_pol = 1'b0;
  logic          rd_stb = 1'b0;
  logic          shutdown = 1'b0;
  logic          alert_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  tstat_alert i_tstat_alert (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_temp(smp_temp),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .tmode(tmode), .fq_sel(fq_sel),
    .alert_pol(alert_pol), .rd_stb(rd_stb), .shutdown(shutdown),
    .alert_o(alert_o)
  );

  task automatic chk(input logic exp_act, input string tag);
    logic e;
    e = alert_pol ? exp_act : !exp_act;
    n_cmp++;
    if (alert_o !== e) begin
      n_bad++;
      $display("FAIL %s: alert_o=%0b expected %0b", tag, alert_o, e);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [1:0] q, input logic p);
    @(negedge clk);
    rst_n = 1'b0; smp_vld = 1'b0; rd_stb = 1'b0; shutdown = 1'b0;
    tmode = m; fq_sel = q; alert_pol = p; lim_hi = HI; lim_lo = LO;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one strobed sample (optionally with a read), ends after capture edge
  task automatic smp(input logic [TW-1:0] t, input logic rd);
    smp_temp = t; smp_vld = 1'b1; rd_stb = rd;
    @(negedge clk);
    smp_vld = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic rd_only();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(2'd0, 2'd0, 1'b0);
    chk(1'b0, "R1 reset inactive");
    smp(MID, 1'b0);
    chk(1'b0, "R1 mid sample");
  endtask

  task automatic t_comparator();
    do_reset(2'd0, 2'd2, 1'b0);
    repeat (3) smp(HOT, 1'b0);
    chk(1'b0, "R4 three hot of four");
    smp(MID, 1'b0);
    repeat (3) smp(HOT, 1'b0);
    chk(1'b0, "R3 run broken");
    smp(HOT, 1'b0);
    chk(1'b1, "R4 fourth hot asserts");
    repeat (3) smp(COLD, 1'b0);
    smp(MID, 1'b0);
    repeat (3) smp(COLD, 1'b0);
    chk(1'b1, "R3 cold run broken");
    smp(COLD, 1'b0);
    chk(1'b0, "R4 fourth cold deasserts");
  endtask

  task automatic t_queue();
    int need [4] = '{1, 2, 4, 6};
    for (int q = 0; q < 4; q++) begin
      do_reset(2'd0, 2'(q), 1'b0);
      for (int k = 0; k < need[q] - 1; k++) smp(HOT, 1'b0);
      chk(1'b0, $sformatf("R3 sel %0d short run", q));
      smp(HOT, 1'b0);
      chk(1'b1, $sformatf("R3 sel %0d full run", q));
    end
  endtask

  task automatic t_bounds();
    do_reset(2'd0, 2'd0, 1'b0);
    smp(HI, 1'b0);
    chk(1'b1, "R2 equal to upper is hot");
    smp(LO, 1'b0);
    chk(1'b1, "R2 equal to lower not cold");
    smp(LO - 13'd1, 1'b0);
    chk(1'b0, "R2 just below lower is cold");
    lim_hi = -13'sd16; lim_lo = -13'sd32;
    smp(13'd100, 1'b0);
    chk(1'b1, "R2 signed positive above negative limit");
    smp(-13'sd32, 1'b0);
    chk(1'b1, "R2 signed equal lower");
    smp(-13'sd33, 1'b0);
    chk(1'b0, "R2 signed below lower");
  endtask

  task automatic t_reserved();
    do_reset(2'd3, 2'd0, 1'b0);
    smp(HOT, 1'b0);
    chk(1'b1, "R4 mode 3 asserts");
    rd_only();
    chk(1'b1, "R10 read ignored in comparator");
    smp(COLD, 1'b0);
    chk(1'b0, "R4 mode 3 deasserts");
  endtask

  task automatic t_interrupt();
    do_reset(2'd1, 2'd0, 1'b0);
    smp(HOT, 1'b0);
    chk(1'b1, "R5 hot asserts");
    smp(COLD, 1'b0);
    chk(1'b1, "R5 held through cold");
    rd_only();
    chk(1'b0, "R5 read clears");
    smp(HOT, 1'b0);
    chk(1'b0, "R6 hot ignored while armed cold");
    smp(COLD, 1'b0);
    chk(1'b1, "R6 cold asserts");
    smp(HOT, 1'b0);
    chk(1'b1, "R6 held through hot");
    rd_only();
    chk(1'b0, "R6 second read clears");
    smp(HOT, 1'b0);
    chk(1'b1, "R6 rearmed for hot");
    shutdown = 1'b1;
    @(negedge clk);
    chk(1'b0, "R5 shutdown entry clears");
    @(negedge clk);
    shutdown = 1'b0;
    chk(1'b0, "R5 shutdown level no reassert");
  endtask

  task automatic t_mixed();
    do_reset(2'd2, 2'd1, 1'b0);
    smp(HOT, 1'b0); smp(HOT, 1'b0);
    chk(1'b1, "R7 hot run asserts");
    rd_only();
    chk(1'b1, "R7 early read ignored");
    smp(COLD, 1'b0);
    smp(COLD, 1'b1);
    chk(1'b1, "R7 read with completing cold not later");
    rd_only();
    chk(1'b0, "R7 later read clears");
  endtask

  task automatic t_same_cycle();
    do_reset(2'd2, 2'd0, 1'b0);
    smp(HOT, 1'b0);
    smp(COLD, 1'b0);
    chk(1'b1, "R9 mixed pending");
    smp(HOT, 1'b1);
    chk(1'b1, "R9 mixed clear then hot reasserts");
    smp(COLD, 1'b0);
    rd_only();
    chk(1'b0, "R9 mixed clear after");
    do_reset(2'd1, 2'd0, 1'b0);
    smp(HOT, 1'b0);
    smp(HOT, 1'b1);
    chk(1'b0, "R9 interrupt clear then hot ignored");
    smp(COLD, 1'b1);
    chk(1'b1, "R9 interrupt idle read with cold asserts");
  endtask

  task automatic t_polarity();
    do_reset(2'd0, 2'd0, 1'b1);
    if (alert_o !== 1'b0) begin n_bad++; $display("FAIL R8 idle high-pol: alert_o=%0b expected 0", alert_o); end
    n_cmp++;
    smp(HOT, 1'b0);
    chk(1'b1, "R8 active high");
    #1 alert_pol = 1'b0;
    #1 chk(1'b1, "R8 flip to active low");
  endtask

  task automatic t_strobe();
    do_reset(2'd0, 2'd0, 1'b0);
    smp_temp = HOT;
    repeat (4) @(negedge clk);
    chk(1'b0, "R10 no strobe no alert");
    smp(HOT, 1'b0);
    smp_temp = COLD;
    repeat (4) @(negedge clk);
    chk(1'b1, "R10 cold without strobe ignored");
  endtask

  initial begin
    t_reset();
    t_comparator();
    t_queue();
    t_bounds();
    t_reserved();
    t_interrupt();
    t_mixed();
    t_same_cycle();
    t_polarity();
    t_strobe();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule